// File: doc/BRIEF.md
# Stream Input Port with Drainable Queue

This block terminates one stream channel at the input of a compute page or a memory block. The upstream link delivers one data token per cycle together with a valid bit. The port sends a registered-free back-pressure bit (`link_stall`) upstream. Because the link has a fixed latency of `LINK_LAT` cycles, stall is raised while enough room is left for the tokens already in flight. Tokens sit in a small circular queue. The local page logic reads them with blocking semantics: it may take a token only while `rd_valid` is high, and it never receives stale data.

For a context swap the page raises `halt`. Reads are blocked at once, but the queue keeps absorbing tokens that were already in flight. A small state machine tracks the drain and has three states:

- RUN: normal operation.
- DRAIN: the port is halted and waiting for a quiet link.
- SETTLED: the port is halted and the link has been quiet for `LINK_LAT` cycles. The `drained` output is high in this state.

The state changes on these transitions:

- RUN→DRAIN when `halt` is high.
- DRAIN→SETTLED after `LINK_LAT` consecutive cycles with no valid token.
- SETTLED→DRAIN when a token arrives.
- DRAIN→RUN or SETTLED→RUN when `halt` falls.

In SETTLED the queue can be saved and restored through a context port. Entries are read and written relative to the queue head, and a commit sets the occupancy.

Top module: `stream_in_port`

## Requirements
- R1: After reset the queue is empty (`q_count`=0, `q_empty`=1), and `link_stall`, `q_full`, `rd_valid` and `drained` are all 0.
- R2: Every cycle with `link_valid`=1 and the queue not full enqueues `link_data`. Tokens leave at `rd_data` in arrival order.
- R3: With the queue empty, `rd_valid` is 0 and `rd_take` has no effect, so `q_count` stays 0.
- R4: `link_stall` is 1 exactly when `q_count` >= DEPTH-LINK_LAT. With DEPTH=8 and LINK_LAT=1 that means at 7 or more.
- R5: Tokens arriving after stall rises (the skid) are still stored up to `q_full`=1 at DEPTH entries. A token arriving while full is dropped, and `q_count` stays at DEPTH.
- R6: An enqueue and a dequeue in the same cycle leave `q_count` unchanged.
- R7: While `halt`=1, `rd_valid` is 0 and `rd_take` is ignored, but arriving tokens are still enqueued.
- R8: `drained` rises once `halt` is high and `link_valid` has been low for LINK_LAT consecutive cycles counted after the halt is seen. A token arrival or a low `halt` clears `drained` on the next edge.
- R9: `ctx_rdata` shows the queue entry `ctx_idx` positions behind the head. Index 0 is the next token to be read.
- R10: Only in the SETTLED state, with no token arriving, does `ctx_wr` write `ctx_wdata` at head+`ctx_idx` and `ctx_commit` set `q_count` to `ctx_count`. In any other state both are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_valid | input | 1 | Token present on the link this cycle |
| link_data | input | W | Token value |
| link_stall | output | 1 | Back-pressure to the producer |
| halt | input | 1 | Page halted for context swap |
| rd_take | input | 1 | Consumer takes the head token |
| rd_valid | output | 1 | Head token may be taken |
| rd_data | output | W | Head token |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |
| q_count | output | $clog2(DEPTH)+1 | Occupancy |
| drained | output | 1 | Halted and link quiet |
| ctx_idx | input | $clog2(DEPTH) | Context entry index from head |
| ctx_rdata | output | W | Context read data |
| ctx_wr | input | 1 | Context entry write |
| ctx_wdata | input | W | Context write data |
| ctx_commit | input | 1 | Load occupancy from ctx_count |
| ctx_count | input | $clog2(DEPTH)+1 | Occupancy to restore |

## Verification
A wrong pointer or occupancy shows up at `rd_data` or `q_count` within the cycle after the faulty update. It also shows through `link_stall` as soon as the count crosses the threshold. A wrong drain state shows on `drained` one edge early or late, or as a `rd_valid` that stays high under halt. A mishandled context write shows at `ctx_rdata` immediately, and at `rd_data` once the port resumes.

// File: rtl/sip_pkg.sv
`timescale 1ns/1ps
package sip_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_SETTLED = 2'd2
    } sip_state_t;
endpackage

// File: rtl/sip_queue_mem.sv
`timescale 1ns/1ps
module sip_queue_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_addr] <= wr_data;
    end

    assign ra_data = slots[ra_addr];
    assign rb_data = slots[rb_addr];
endmodule

// File: rtl/sip_drain_fsm.sv
`timescale 1ns/1ps
module sip_drain_fsm
    import sip_pkg::*;
#(
    parameter int LINK_LAT = 1,
    localparam int QW      = $clog2(LINK_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic link_valid,
    output logic is_run,
    output logic is_settled
);
    localparam logic [QW-1:0] QLAST = QW'(LINK_LAT - 1);

    sip_state_t state, state_nx;
    logic [QW-1:0] quiet;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (halt) state_nx = ST_DRAIN;
            ST_DRAIN:   if (!halt) state_nx = ST_RUN;
                        else if (!link_valid && quiet == QLAST) state_nx = ST_SETTLED;
            ST_SETTLED: if (!halt) state_nx = ST_RUN;
                        else if (link_valid) state_nx = ST_DRAIN;
            default:    state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            quiet <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_DRAIN || link_valid) quiet <= '0;
            else if (quiet != QLAST) quiet <= quiet + 1'b1;
        end
    end

    always_comb begin
        is_run     = (state == ST_RUN);
        is_settled = (state == ST_SETTLED);
    end

    // R8
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_settled) |-> ($past(halt) && !$past(link_valid)));
endmodule

// File: rtl/stream_in_port.sv
`timescale 1ns/1ps
module stream_in_port #(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter int LINK_LAT = 1,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_valid,
    input  logic [W-1:0]  link_data,
    output logic          link_stall,
    input  logic          halt,
    input  logic          rd_take,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic          q_empty,
    output logic          q_full,
    output logic [CW-1:0] q_count,
    output logic          drained,
    input  logic [AW-1:0] ctx_idx,
    output logic [W-1:0]  ctx_rdata,
    input  logic          ctx_wr,
    input  logic [W-1:0]  ctx_wdata,
    input  logic          ctx_commit,
    input  logic [CW-1:0] ctx_count
);
    localparam logic [CW-1:0] THRESH = CW'(DEPTH - LINK_LAT);
    localparam logic [CW-1:0] FULLV  = CW'(DEPTH);

    logic [AW-1:0] head, tail;
    logic          is_run, is_settled;
    logic          enq, deq, ctx_ok, commit_w, mem_we;
    logic [AW-1:0] ctx_addr, mem_wa;
    logic [W-1:0]  mem_wd;

    sip_drain_fsm #(.LINK_LAT(LINK_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .link_valid(link_valid),
        .is_run(is_run), .is_settled(is_settled)
    );

    assign q_empty    = (q_count == '0);
    assign q_full     = (q_count == FULLV);
    assign link_stall = (q_count >= THRESH);
    assign drained    = is_settled;
    assign rd_valid   = !q_empty && is_run && !halt;
    assign enq        = link_valid && !q_full;
    assign deq        = rd_take && rd_valid;
    assign ctx_ok     = is_settled && !link_valid;
    assign commit_w   = ctx_ok && ctx_commit;
    assign ctx_addr   = head + ctx_idx;
    assign mem_we     = enq || (ctx_ok && ctx_wr);
    assign mem_wa     = enq ? tail : ctx_addr;
    assign mem_wd     = enq ? link_data : ctx_wdata;

    sip_queue_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(mem_we), .wr_addr(mem_wa), .wr_data(mem_wd),
        .ra_addr(head), .ra_data(rd_data),
        .rb_addr(ctx_addr), .rb_data(ctx_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            q_count <= '0;
        end else if (commit_w) begin
            tail    <= head + ctx_count[AW-1:0];
            q_count <= ctx_count;
        end else begin
            if (enq) tail <= tail + 1'b1;
            if (deq) head <= head + 1'b1;
            unique case ({enq, deq})
                2'b10:   q_count <= q_count + 1'b1;
                2'b01:   q_count <= q_count - 1'b1;
                default: q_count <= q_count;
            endcase
        end
    end

    // R4
    stall_before_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !$past(commit_w)) |-> $past(link_stall));
    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_w |=> (q_count == $past(q_count) || q_count == $past(q_count) + 1'b1
                       || q_count + 1'b1 == $past(q_count)));
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !commit_w) |=> (q_count >= $past(q_count)));
    // R3
    empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && rd_take) |=> (q_count <= 1));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= FULLV);
endmodule

// File: tb/sim_stream_in_port.sv
`timescale 1ns/1ps
module sim_stream_in_port;
    localparam int W = 8, DEPTH = 8, LAT = 1;

    logic clk = 0, rst_n = 0;
    logic link_valid = 0, halt = 0, rd_take = 0, ctx_wr = 0, ctx_commit = 0;
    logic [7:0] link_data = 0, ctx_wdata = 0, rd_data, ctx_rdata;
    logic [2:0] ctx_idx = 0;
    logic [3:0] ctx_count = 0, q_count;
    logic link_stall, rd_valid, q_empty, q_full, drained;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    stream_in_port #(.W(W), .DEPTH(DEPTH), .LINK_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_data(link_data),
        .link_stall(link_stall), .halt(halt), .rd_take(rd_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
        .drained(drained), .ctx_idx(ctx_idx), .ctx_rdata(ctx_rdata), .ctx_wr(ctx_wr),
        .ctx_wdata(ctx_wdata), .ctx_commit(ctx_commit), .ctx_count(ctx_count)
    );

    // {valid, data[7:0], take, halt, count[3:0], stall, drained}
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 8'h11, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0},   // R2
        {1'b1, 8'h22, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0},   // R2
        {1'b1, 8'h33, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0},   // R6
        {1'b0, 8'h00, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0},   // R8 enter drain
        {1'b1, 8'h44, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0},   // R7
        {1'b0, 8'h00, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1},   // R8
        {1'b0, 8'h00, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0},   // R8 release
        {1'b0, 8'h00, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0}    // R2
    };

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick; tick;
        rst_n = 1; #1;
        chk("R1 count", q_count, 0);
        chk("R1 empty", q_empty, 1);
        chk("R1 stall", link_stall, 0);
        chk("R1 full", q_full, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 drained", drained, 0);

        for (int i = 0; i < 8; i++) begin
            {link_valid, link_data, rd_take, halt} = VEC[i][16:6];
            tick;
            chk("R2/R6/R7/R8 count", q_count, VEC[i][5:2]);
            chk("R4 stall", link_stall, VEC[i][1]);
            chk("R8 drained", drained, VEC[i][0]);
        end
        link_valid = 0; rd_take = 0; halt = 0; #1;

        chk("R2 order head", rd_data, 8'h33);
        chk("R2 rd_valid", rd_valid, 1);
        rd_take = 1; tick;
        chk("R2 order next", rd_data, 8'h44);
        tick;
        rd_take = 0; #1;
        chk("R3 empty", q_empty, 1);
        chk("R3 rd_valid", rd_valid, 0);
        rd_take = 1; tick; rd_take = 0;
        chk("R3 take ignored", q_count, 0);

        for (int i = 0; i < 8; i++) begin
            link_valid = 1; link_data = 8'h60 + 8'(i);
            tick;
            chk("R5 fill count", q_count, i + 1);
            chk("R4 stall level", link_stall, (i + 1 >= DEPTH - LAT) ? 1 : 0);
        end
        chk("R5 full", q_full, 1);
        link_data = 8'hFF; tick; link_valid = 0;
        chk("R5 drop at full", q_count, 8);
        rd_take = 1; tick;
        chk("R4 stall held", link_stall, 1);
        tick; rd_take = 0; #1;
        chk("R4 stall released", link_stall, 0);
        chk("R2 head after fill", rd_data, 8'h62);

        ctx_commit = 1; ctx_count = 4'd3; tick; ctx_commit = 0;
        chk("R10 commit ignored in run", q_count, 6);

        halt = 1; tick; tick;
        chk("R8 drained after quiet", drained, 1);
        for (int i = 0; i < 6; i++) begin
            ctx_idx = 3'(i); #1;
            chk("R9 ctx read", ctx_rdata, 8'h62 + i);
        end
        ctx_wr = 1; ctx_idx = 0; ctx_wdata = 8'hA0; tick;
        ctx_idx = 1; ctx_wdata = 8'hA1; tick; ctx_wr = 0;
        ctx_commit = 1; ctx_count = 4'd2; tick; ctx_commit = 0;
        chk("R10 restored count", q_count, 2);
        chk("R8 still drained", drained, 1);
        link_valid = 1; link_data = 8'h77; tick; link_valid = 0;
        chk("R8 clear on arrival", drained, 0);
        chk("R7 arrival under halt", q_count, 3);
        halt = 0; tick;
        chk("R10 restored head", rd_data, 8'hA0);
        rd_take = 1; tick; rd_take = 0; #1;
        chk("R10 restored next", rd_data, 8'hA1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule